// File: doc/BRIEF.md
# Full-Descending Stack Pointer Controller

This block owns the byte-address stack pointer of a small core and turns single-word push and pop requests into accesses on an external single-port word memory that has a synchronous read. The stack grows toward lower addresses and the pointer always names the lowest occupied byte address, so the word at the pointer is the current top item. A push moves the pointer down by four bytes before the store goes out. A pop reads the word at the pointer first and only raises the pointer by four once the read data has come back.

Each request runs a short fixed sequence through a named state machine. The states are ST_IDLE, ST_PUSH_DEC, ST_PUSH_WR, ST_POP_RD and ST_POP_WAIT. The transitions are: ST_IDLE to ST_PUSH_DEC on an accepted push, ST_IDLE to ST_POP_RD on an accepted pop, ST_PUSH_DEC to ST_PUSH_WR, ST_PUSH_WR to ST_IDLE, ST_POP_RD to ST_POP_WAIT, and ST_POP_WAIT to ST_IDLE. A request that would leave the permitted window is refused in ST_IDLE. A refused request raises a sticky error flag and leaves the pointer where it was. The top-of-stack and limit parameters must be multiples of four.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, sp equals TOP_ADDR, and busy, err, pop_valid and mem_we are all 0. sp stays a multiple of 4 at all times.
- R2: A push accepted in ST_IDLE makes busy 1 for exactly two cycles. In the first cycle sp is still the old value. In the second cycle sp equals the old value minus 4, mem_we is 1, mem_addr equals the new sp divided by 4 (sp bits [ADDR_W-1:2]), and mem_wdata carries the pushed data.
- R3: A pop accepted in ST_IDLE makes busy 1 for two cycles. During the first of them, mem_addr equals the old sp divided by 4 and sp is unchanged. In the cycle after the second, pop_valid is 1 for exactly one cycle and sp equals the old value plus 4.
- R4: Popped words come out in last-in-first-out order. pop_data holds the word most recently pushed and not yet popped.
- R5: After any balanced sequence of pushes and pops, sp is back at its starting value.
- R6: Push or pop requests that arrive while busy is 1 are ignored. They cause no change to sp, no memory write and no pop_valid pulse.
- R7: When push_req and pop_req are both 1 in ST_IDLE, only the push is carried out.
- R8: A pop requested while sp equals TOP_ADDR sets err. It leaves sp unchanged, does not assert busy, and produces no pop_valid pulse.
- R9: A push requested while sp minus 4 would fall below LIMIT_ADDR sets err. It leaves sp unchanged, does not assert busy, and produces no memory write.
- R10: Once err is set it stays 1 through later operations until reset clears it.
- R11: sp never leaves the range LIMIT_ADDR to TOP_ADDR, and mem_we is only 1 while busy is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request to push push_data |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | DATA_W | Word to be pushed |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| mem_addr | output | ADDR_W-2 | Word address driven to the memory |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| pop_data | output | DATA_W | Popped word |
| pop_valid | output | 1 | One-cycle strobe qualifying pop_data |
| sp | output | ADDR_W | Current stack pointer (byte address) |
| busy | output | 1 | A request is in progress |
| err | output | 1 | Sticky underflow/limit error |

## Verification
The bench builds the block with an 8-bit address, 16-bit data, TOP_ADDR 0x40 and LIMIT_ADDR 0x20, which gives a stack eight words deep. Every fill depth from one to eight is then swept with a full push-then-pop cycle. With so few entries, both refusal boundaries are cheap to reach: the ninth push and the pop from an empty stack. The bench also covers interleaved orderings, requests raised during busy cycles, simultaneous requests, and clearing the sticky flag by reset. All of these are checked against an arithmetic pointer model and a model stack array.

// File: rtl/stack_pkg.sv
package stack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_DEC,
        ST_PUSH_WR,
        ST_POP_RD,
        ST_POP_WAIT
    } stk_state_t;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_DEC,
        SP_INC
    } sp_op_t;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/stack_sp_reg.sv
module stack_sp_reg
    import stack_pkg::*;
#(
    parameter int unsigned     ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] TOP_ADDR   = ADDR_W'(256),
    parameter logic [ADDR_W-1:0] LIMIT_ADDR = ADDR_W'(224)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sp_op_t            sp_op,
    output logic [ADDR_W-1:0] sp,
    output logic              push_blocked,
    output logic              pop_blocked
);

    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W:0]   PUSH_FLOOR = {1'b0, LIMIT_ADDR} + (ADDR_W+1)'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= TOP_ADDR;
        end else begin
            unique case (sp_op)
                SP_DEC:  sp <= sp - STEP;
                SP_INC:  sp <= sp + STEP;
                default: sp <= sp;
            endcase
        end
    end

    always_comb begin
        push_blocked = ({1'b0, sp} < PUSH_FLOOR);
        pop_blocked  = (sp == TOP_ADDR);
    end

endmodule

// File: rtl/stack_data_regs.sv
module stack_data_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wdata,
    input  logic [DATA_W-1:0] push_data,
    input  logic              capture_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q   <= '0;
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            if (load_wdata) begin
                wdata_q <= push_data;
            end
            if (capture_rd) begin
                pop_data <= mem_rdata;
            end
            pop_valid <= capture_rd;
        end
    end

endmodule

// File: rtl/stack_seq_fsm.sv
module stack_seq_fsm
    import stack_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_req,
    input  logic   pop_req,
    input  logic   push_blocked,
    input  logic   pop_blocked,
    output logic   busy,
    output logic   mem_we,
    output sp_op_t sp_op,
    output logic   load_wdata,
    output logic   capture_rd,
    output logic   err
);

    stk_state_t state_q;
    stk_state_t state_d;
    logic       err_set;

    // state register and sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            err     <= err | err_set;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (push_req) begin
                    state_d = push_blocked ? ST_IDLE : ST_PUSH_DEC;
                end else if (pop_req) begin
                    state_d = pop_blocked ? ST_IDLE : ST_POP_RD;
                end
            end
            ST_PUSH_DEC: state_d = ST_PUSH_WR;
            ST_PUSH_WR:  state_d = ST_IDLE;
            ST_POP_RD:   state_d = ST_POP_WAIT;
            ST_POP_WAIT: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        mem_we     = 1'b0;
        sp_op      = SP_HOLD;
        load_wdata = 1'b0;
        capture_rd = 1'b0;
        err_set    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (push_req) begin
                    load_wdata = !push_blocked;
                    err_set    = push_blocked;
                end else if (pop_req) begin
                    err_set    = pop_blocked;
                end
            end
            ST_PUSH_DEC: sp_op = SP_DEC;
            ST_PUSH_WR:  mem_we = 1'b1;
            ST_POP_RD:   sp_op = SP_HOLD;
            ST_POP_WAIT: begin
                capture_rd = 1'b1;
                sp_op      = SP_INC;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stack_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [ADDR_W-1:0] TOP_ADDR   = ADDR_W'(256),
    parameter logic [ADDR_W-1:0] LIMIT_ADDR = ADDR_W'(224)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-3:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [ADDR_W-1:0] sp,
    output logic              busy,
    output logic              err
);

    sp_op_t sp_op;
    logic   push_blocked;
    logic   pop_blocked;
    logic   load_wdata;
    logic   capture_rd;

    stack_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_req     (push_req),
        .pop_req      (pop_req),
        .push_blocked (push_blocked),
        .pop_blocked  (pop_blocked),
        .busy         (busy),
        .mem_we       (mem_we),
        .sp_op        (sp_op),
        .load_wdata   (load_wdata),
        .capture_rd   (capture_rd),
        .err          (err)
    );

    stack_sp_reg #(
        .ADDR_W     (ADDR_W),
        .TOP_ADDR   (TOP_ADDR),
        .LIMIT_ADDR (LIMIT_ADDR)
    ) u_sp (
        .clk          (clk),
        .rst_n        (rst_n),
        .sp_op        (sp_op),
        .sp           (sp),
        .push_blocked (push_blocked),
        .pop_blocked  (pop_blocked)
    );

    stack_data_regs #(
        .DATA_W (DATA_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wdata (load_wdata),
        .push_data  (push_data),
        .capture_rd (capture_rd),
        .mem_rdata  (mem_rdata),
        .wdata_q    (mem_wdata),
        .pop_data   (pop_data),
        .pop_valid  (pop_valid)
    );

    assign mem_addr = sp[ADDR_W-1:2];

endmodule

// File: rtl/stack_ptr_chk.sv
module stack_ptr_chk #(
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] TOP_ADDR   = ADDR_W'(256),
    parameter logic [ADDR_W-1:0] LIMIT_ADDR = ADDR_W'(224)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              pop_valid,
    input logic [ADDR_W-1:0] sp,
    input logic              busy,
    input logic              err
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    // R1
    sp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp[1:0] == 2'b00);

    // R11
    sp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp >= LIMIT_ADDR) && (sp <= TOP_ADDR));

    // R11
    we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R2
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(sp) == sp + STEP));

    // R2
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R3
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> (sp == $past(sp) + STEP));

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> !pop_valid);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

bind stack_ptr_unit stack_ptr_chk #(
    .ADDR_W     (ADDR_W),
    .TOP_ADDR   (TOP_ADDR),
    .LIMIT_ADDR (LIMIT_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .pop_valid (pop_valid),
    .sp        (sp),
    .busy      (busy),
    .err       (err)
);

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;

    localparam int unsigned   CLK_PERIOD = 10;
    localparam int unsigned   AW  = 8;
    localparam int unsigned   DW  = 16;
    localparam logic [AW-1:0] TOP = 8'h40;
    localparam logic [AW-1:0] LIM = 8'h20;
    localparam int unsigned   CAP = (TOP - LIM) / 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          push_req;
    logic          pop_req;
    logic [DW-1:0] push_data;
    logic [DW-1:0] mem_rdata;
    logic [AW-3:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] pop_data;
    logic          pop_valid;
    logic [AW-1:0] sp;
    logic          busy;
    logic          err;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem [0:63];
    logic [DW-1:0] model [0:15];
    int            depth;
    logic [AW-1:0] exp_sp;
    logic          exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    stack_ptr_unit #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .TOP_ADDR   (TOP),
        .LIMIT_ADDR (LIM)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .sp        (sp),
        .busy      (busy),
        .err       (err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; push_req = 1'b0; pop_req = 1'b0; push_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_sp = TOP; exp_err = 1'b0; depth = 0;
    endtask

    task automatic do_push(input logic [DW-1:0] d, input logic with_pop);
        logic [AW-1:0] s0 = exp_sp;
        logic blocked = (s0 < LIM + 8'd4);
        @(negedge clk);
        push_req = 1'b1; pop_req = with_pop; push_data = d;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        if (blocked) begin
            exp_err = 1'b1;
            chk("R9 busy on refused push", 32'(busy), 0);
            chk("R9 err on refused push", 32'(err), 1);
            chk("R9 sp kept", 32'(sp), 32'(s0));
            chk("R9 no write", 32'(mem_we), 0);
            return;
        end
        chk("R2 busy first cycle", 32'(busy), 1);
        chk("R2 sp held first cycle", 32'(sp), 32'(s0));
        @(negedge clk);
        chk("R2 sp decremented", 32'(sp), 32'(s0 - 8'd4));
        chk("R2 write enable", 32'(mem_we), 1);
        chk("R2 write address", 32'(mem_addr), 32'((s0 - 8'd4) >> 2));
        chk("R2 write data", 32'(mem_wdata), 32'(d));
        @(negedge clk);
        chk("R2 idle after push", 32'(busy), 0);
        chk("R7 no pop pulse", 32'(pop_valid), 0);
        chk("R10 err flag", 32'(err), 32'(exp_err));
        exp_sp = s0 - 8'd4;
        model[depth] = d;
        depth++;
    endtask

    task automatic do_pop();
        logic [AW-1:0] s0 = exp_sp;
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        if (s0 == TOP) begin
            exp_err = 1'b1;
            chk("R8 busy on refused pop", 32'(busy), 0);
            chk("R8 err on refused pop", 32'(err), 1);
            chk("R8 sp kept", 32'(sp), 32'(s0));
            repeat (2) begin
                @(negedge clk);
                chk("R8 no pop pulse", 32'(pop_valid), 0);
            end
            return;
        end
        chk("R3 busy first cycle", 32'(busy), 1);
        chk("R3 read address", 32'(mem_addr), 32'(s0 >> 2));
        chk("R3 sp held", 32'(sp), 32'(s0));
        @(negedge clk);
        chk("R3 sp held until data", 32'(sp), 32'(s0));
        @(negedge clk);
        depth--;
        chk("R3 valid pulse", 32'(pop_valid), 1);
        chk("R4 lifo data", 32'(pop_data), 32'(model[depth]));
        chk("R3 sp incremented", 32'(sp), 32'(s0 + 8'd4));
        chk("R3 idle after pop", 32'(busy), 0);
        @(negedge clk);
        chk("R3 pulse ends", 32'(pop_valid), 0);
        chk("R10 err flag", 32'(err), 32'(exp_err));
        exp_sp = s0 + 8'd4;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 reset sp", 32'(sp), 32'(TOP));
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset err", 32'(err), 0);
        chk("R1 reset valid", 32'(pop_valid), 0);
        chk("R1 reset we", 32'(mem_we), 0);

        // fill depth sweep, balanced sequences
        for (int n = 1; n <= int'(CAP); n++) begin
            for (int i = 0; i < n; i++) do_push(DW'(n * 97 + i * 13 + 5), 1'b0);
            for (int i = 0; i < n; i++) do_pop();
            chk("R5 balanced sp", 32'(sp), 32'(TOP));
        end

        // interleaved ordering
        do_push(16'hA1A1, 1'b0);
        do_push(16'hB2B2, 1'b0);
        do_pop();
        do_push(16'hC3C3, 1'b0);
        do_pop();
        do_pop();
        chk("R5 interleaved sp", 32'(sp), 32'(TOP));

        // requests while busy are ignored
        begin
            @(negedge clk);
            push_req = 1'b1; push_data = 16'h5A5A;
            @(negedge clk);
            push_req = 1'b0; pop_req = 1'b1; push_data = 16'h0F0F;
            @(negedge clk);
            chk("R6 write data unchanged", 32'(mem_wdata), 32'h5A5A);
            @(negedge clk);
            pop_req = 1'b0;
            chk("R6 sp after ignored pop", 32'(sp), 32'(TOP - 8'd4));
            chk("R6 no pop pulse", 32'(pop_valid), 0);
            @(negedge clk);
            chk("R6 still idle", 32'(busy), 0);
            chk("R6 sp unchanged", 32'(sp), 32'(TOP - 8'd4));
            exp_sp = TOP - 8'd4; model[depth] = 16'h5A5A; depth++;
            do_pop();
        end

        // simultaneous requests: push wins
        do_push(16'h7E57, 1'b1);
        do_pop();
        chk("R7 sp after pair", 32'(sp), 32'(TOP));

        // limit, then underflow, sticky flag
        for (int i = 0; i < int'(CAP); i++) do_push(DW'(i * 311 + 7), 1'b0);
        chk("R9 full sp at limit", 32'(sp), 32'(LIM));
        do_push(16'hDEAD, 1'b0);
        for (int i = 0; i < int'(CAP); i++) do_pop();
        chk("R10 err held", 32'(err), 1);
        do_pop();
        do_reset();
        chk("R10 err cleared by reset", 32'(err), 0);
        do_pop();
        chk("R8 sp after empty pop", 32'(sp), 32'(TOP));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule